// File: doc/BRIEF.md
# Parallel Order Match Store

A table of pending orders sits next to a quote stream. An upstream pricing engine loads orders into numbered slots through a write port. Each order holds an instrument key, a side (buy or sell), a limit price and a remaining quantity. When an exchange quote is accepted on the valid/ready input, the block compares every slot against it in the same cycle, picks one crossing order and emits an outbound order. It then reduces the chosen slot's remaining quantity by the amount sent.

The comparison is spread across all slots at once. The winner's fields come out through a lowest-index priority pick and a one-hot AND-OR multiplexer, with no shared bus. The match decision and the pick are registered in a first stage. The decrement and the outbound order are committed in a second stage. A quote is therefore answered a fixed two cycles after it is presented, or not at all.

Order writes and quote-driven decrements can land on the same slot. A write from the pricing engine always overrides a decrement. An order that has already been chosen is still emitted.

Top module: `order_match_store`

## Requirements
- R1: After reset every slot is empty, `o_valid` is 0 and `q_ready` is 1; a quote presented to an empty table produces no order.
- R2: A buy slot (`side` 0) matches a quote when the slot is occupied, its key equals `q_key`, `q_size` is nonzero and `q_ask` is at or below the slot limit. A quote with another key or a higher ask produces no order.
- R3: A sell slot (`side` 1) matches when the slot is occupied, the keys are equal, `q_size` is nonzero and `q_bid` is at or above the slot limit. A lower bid produces no order.
- R4: When several slots match, the slot with the lowest index is the one used.
- R5: The outbound order carries the winning slot's index, key, side and limit price. Its quantity is the smaller of the slot's remaining quantity and `q_size`, so it is never zero.
- R6: The winning slot's remaining quantity drops by the quantity sent. A slot whose remaining quantity reaches zero becomes empty and matches nothing afterwards.
- R7: A write stores all fields into slot `wr_slot`. A write with `wr_qty` = 0 empties that slot. A write with `wr_slot` at or above the table depth changes nothing.
- R8: If a write and a hit decrement address the same slot in one cycle, the written contents are kept and the decrement is dropped.
- R9: A quote presented with `q_ready` high in cycle n yields `o_valid` in cycle n+2 and not in cycle n+1; a quote with no match yields no order.
- R10: Quotes accepted in consecutive cycles see the decrement made by the previous hit, so they never send more than the slot held in total.
- R11: While `o_valid` is 1 and `o_ready` is 0, the order fields stay unchanged and `q_ready` is 0; the order leaves one cycle after `o_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | SLOT_W | Slot index to write |
| wr_key | input | KEY_W | Instrument key of the order |
| wr_side | input | 1 | 0 buy, 1 sell |
| wr_price | input | PRICE_W | Limit price |
| wr_qty | input | QTY_W | Quantity; 0 empties the slot |
| q_valid | input | 1 | Quote present |
| q_ready | output | 1 | Quote accepted this cycle when high |
| q_key | input | KEY_W | Quote instrument key |
| q_bid | input | PRICE_W | Quote bid price |
| q_ask | input | PRICE_W | Quote ask price |
| q_size | input | QTY_W | Quote size available |
| o_valid | output | 1 | Outbound order present |
| o_ready | input | 1 | Downstream takes the order |
| o_slot | output | SLOT_W | Slot that produced the order |
| o_key | output | KEY_W | Instrument key |
| o_side | output | 1 | Side of the order |
| o_price | output | PRICE_W | Order price, the slot limit |
| o_qty | output | QTY_W | Order quantity |

## Verification
A wrong remaining quantity or occupied bit in a slot stays hidden until the next quote on that key. It then shows at the ports two cycles later as a wrong `o_qty`, an order that should not exist, or a missing one. The bench therefore follows each write and each hit with further quotes on the same key, and drains slots to exhaustion. A bad priority pick shows as a wrong `o_slot` on the very quote that exposes two candidates. Collisions between writes and decrements, and back-to-back quotes, are timed to the exact cycle, because a missing forward or a lost write changes the quantity of the following order.

// File: rtl/oms_pkg.sv
package oms_pkg;
  typedef enum logic {
    SIDE_BUY  = 1'b0,
    SIDE_SELL = 1'b1
  } side_e;
endpackage

// File: rtl/oms_table.sv
module oms_table #(
  parameter int DEPTH   = 200,
  parameter int SLOT_W  = 8,
  parameter int KEY_W   = 16,
  parameter int PRICE_W = 32,
  parameter int QTY_W   = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SLOT_W-1:0]               wr_slot,
  input  logic [KEY_W-1:0]                wr_key,
  input  logic                            wr_side,
  input  logic [PRICE_W-1:0]              wr_price,
  input  logic [QTY_W-1:0]                wr_qty,
  input  logic                            dec_en,
  input  logic [SLOT_W-1:0]               dec_slot,
  input  logic [QTY_W-1:0]                dec_rem,
  output logic [DEPTH-1:0]                ent_valid,
  output logic [DEPTH-1:0][KEY_W-1:0]     ent_key,
  output logic [DEPTH-1:0]                ent_side,
  output logic [DEPTH-1:0][PRICE_W-1:0]   ent_price,
  output logic [DEPTH-1:0][QTY_W-1:0]     ent_qty
);

  // a write and a decrement on the same slot in the same cycle
  logic wr_clash;
  assign wr_clash = wr_en && dec_en && (wr_slot == dec_slot);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_here, dec_here;
    assign wr_here  = wr_en  && (wr_slot  == SLOT_W'(i));
    assign dec_here = dec_en && (dec_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_key[i]   <= '0;
        ent_side[i]  <= 1'b0;
        ent_price[i] <= '0;
        ent_qty[i]   <= '0;
      end else if (wr_here) begin
        ent_valid[i] <= (wr_qty != '0);
        ent_key[i]   <= wr_key;
        ent_side[i]  <= wr_side;
        ent_price[i] <= wr_price;
        ent_qty[i]   <= wr_qty;
      end else if (dec_here) begin
        ent_valid[i] <= (dec_rem != '0);
        ent_qty[i]   <= dec_rem;
      end
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clash |=> (ent_qty[$past(wr_slot)] == $past(wr_qty))); // R8

  AST_RETIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && dec_rem == '0 && !wr_clash) |=> !ent_valid[$past(dec_slot)]); // R6

endmodule

// File: rtl/oms_match.sv
module oms_match #(
  parameter int DEPTH   = 200,
  parameter int SLOT_W  = 8,
  parameter int KEY_W   = 16,
  parameter int PRICE_W = 32,
  parameter int QTY_W   = 24
) (
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0][KEY_W-1:0]   ent_key,
  input  logic [DEPTH-1:0]              ent_side,
  input  logic [DEPTH-1:0][PRICE_W-1:0] ent_price,
  input  logic                          fwd_en,
  input  logic [SLOT_W-1:0]             fwd_slot,
  input  logic [QTY_W-1:0]              fwd_rem,
  input  logic [KEY_W-1:0]              q_key,
  input  logic [PRICE_W-1:0]            q_bid,
  input  logic [PRICE_W-1:0]            q_ask,
  input  logic [QTY_W-1:0]              q_size,
  output logic [DEPTH-1:0]              match_vec
);
  import oms_pkg::*;

  // price condition: buyer pays up to its limit, seller takes at least its limit
  function automatic logic price_crosses(input logic side,
                                         input logic [PRICE_W-1:0] limit,
                                         input logic [PRICE_W-1:0] bid,
                                         input logic [PRICE_W-1:0] ask);
    if (side == SIDE_BUY) return ask <= limit;
    return bid >= limit;
  endfunction

  logic size_ok;
  assign size_ok = (q_size != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic live;
    // the slot held in stage one is seen with its post-hit occupancy
    assign live = (fwd_en && fwd_slot == SLOT_W'(i)) ? (fwd_rem != '0) : ent_valid[i];
    assign match_vec[i] = live && size_ok && (ent_key[i] == q_key) &&
                          price_crosses(ent_side[i], ent_price[i], q_bid, q_ask);
  end

endmodule

// File: rtl/oms_pick.sv
module oms_pick #(
  parameter int DEPTH   = 200,
  parameter int SLOT_W  = 8,
  parameter int KEY_W   = 16,
  parameter int PRICE_W = 32,
  parameter int QTY_W   = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              match_vec,
  input  logic [DEPTH-1:0][KEY_W-1:0]   ent_key,
  input  logic [DEPTH-1:0]              ent_side,
  input  logic [DEPTH-1:0][PRICE_W-1:0] ent_price,
  input  logic [DEPTH-1:0][QTY_W-1:0]   ent_qty,
  output logic                          hit_any,
  output logic [DEPTH-1:0]              hit_onehot,
  output logic [SLOT_W-1:0]             hit_slot,
  output logic [KEY_W-1:0]              hit_key,
  output logic                          hit_side,
  output logic [PRICE_W-1:0]            hit_price,
  output logic [QTY_W-1:0]              hit_qty
);

  // isolate the lowest set bit
  assign hit_onehot = match_vec & (~match_vec + DEPTH'(1));
  assign hit_any    = |match_vec;

  always_comb begin
    hit_slot  = '0;
    hit_key   = '0;
    hit_side  = 1'b0;
    hit_price = '0;
    hit_qty   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_slot  |= {SLOT_W{hit_onehot[i]}}  & SLOT_W'(i);
      hit_key   |= {KEY_W{hit_onehot[i]}}   & ent_key[i];
      hit_side  |= hit_onehot[i]            & ent_side[i];
      hit_price |= {PRICE_W{hit_onehot[i]}} & ent_price[i];
      hit_qty   |= {QTY_W{hit_onehot[i]}}   & ent_qty[i];
    end
  end

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_onehot) && (hit_any == (hit_onehot != '0))); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((match_vec & (hit_onehot - DEPTH'(1))) == '0)); // R4

endmodule

// File: rtl/order_match_store.sv
module order_match_store #(
  parameter int DEPTH   = 200,
  parameter int SLOT_W  = $clog2(DEPTH),
  parameter int KEY_W   = 16,
  parameter int PRICE_W = 32,
  parameter int QTY_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic               wr_side,
  input  logic [PRICE_W-1:0] wr_price,
  input  logic [QTY_W-1:0]   wr_qty,
  input  logic               q_valid,
  output logic               q_ready,
  input  logic [KEY_W-1:0]   q_key,
  input  logic [PRICE_W-1:0] q_bid,
  input  logic [PRICE_W-1:0] q_ask,
  input  logic [QTY_W-1:0]   q_size,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [SLOT_W-1:0]  o_slot,
  output logic [KEY_W-1:0]   o_key,
  output logic               o_side,
  output logic [PRICE_W-1:0] o_price,
  output logic [QTY_W-1:0]   o_qty
);

  function automatic logic [QTY_W-1:0] qty_min(input logic [QTY_W-1:0] a,
                                               input logic [QTY_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // table state
  logic [DEPTH-1:0]              ent_valid;
  logic [DEPTH-1:0][KEY_W-1:0]   ent_key;
  logic [DEPTH-1:0]              ent_side;
  logic [DEPTH-1:0][PRICE_W-1:0] ent_price;
  logic [DEPTH-1:0][QTY_W-1:0]   ent_qty;

  // stage one
  logic               s1_valid, s1_kill;
  logic [SLOT_W-1:0]  s1_slot;
  logic [KEY_W-1:0]   s1_key;
  logic               s1_side;
  logic [PRICE_W-1:0] s1_price;
  logic [QTY_W-1:0]   s1_send, s1_rem;

  // named events
  logic               advance, accept, fwd_en, dec_en, wr_on_s1;
  logic [DEPTH-1:0]   match_vec, hit_onehot;
  logic               hit_any, hit_side;
  logic [SLOT_W-1:0]  hit_slot;
  logic [KEY_W-1:0]   hit_key;
  logic [PRICE_W-1:0] hit_price;
  logic [QTY_W-1:0]   hit_qty, avail_qty, send_qty;

  assign advance  = !o_valid || o_ready;
  assign q_ready  = advance;
  assign accept   = q_valid && advance;
  assign fwd_en   = s1_valid && !s1_kill;
  assign dec_en   = advance && s1_valid && !s1_kill;
  assign wr_on_s1 = wr_en && (wr_slot == s1_slot);

  oms_table #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .KEY_W(KEY_W),
              .PRICE_W(PRICE_W), .QTY_W(QTY_W)) u_table (
    .clk, .rst_n,
    .wr_en, .wr_slot, .wr_key, .wr_side, .wr_price, .wr_qty,
    .dec_en, .dec_slot(s1_slot), .dec_rem(s1_rem),
    .ent_valid, .ent_key, .ent_side, .ent_price, .ent_qty
  );

  oms_match #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .KEY_W(KEY_W),
              .PRICE_W(PRICE_W), .QTY_W(QTY_W)) u_match (
    .ent_valid, .ent_key, .ent_side, .ent_price,
    .fwd_en, .fwd_slot(s1_slot), .fwd_rem(s1_rem),
    .q_key, .q_bid, .q_ask, .q_size,
    .match_vec
  );

  oms_pick #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .KEY_W(KEY_W),
             .PRICE_W(PRICE_W), .QTY_W(QTY_W)) u_pick (
    .clk, .rst_n,
    .match_vec, .ent_key, .ent_side, .ent_price, .ent_qty,
    .hit_any, .hit_onehot, .hit_slot, .hit_key, .hit_side, .hit_price, .hit_qty
  );

  // remaining quantity seen by this quote, including the hit still in stage one
  assign avail_qty = (fwd_en && hit_slot == s1_slot) ? s1_rem : hit_qty;
  assign send_qty  = qty_min(avail_qty, q_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_kill  <= 1'b0;
      s1_slot  <= '0;
      s1_key   <= '0;
      s1_side  <= 1'b0;
      s1_price <= '0;
      s1_send  <= '0;
      s1_rem   <= '0;
    end else if (advance) begin
      s1_valid <= accept && hit_any;
      s1_kill  <= wr_en && (wr_slot == hit_slot);
      s1_slot  <= hit_slot;
      s1_key   <= hit_key;
      s1_side  <= hit_side;
      s1_price <= hit_price;
      s1_send  <= send_qty;
      s1_rem   <= avail_qty - send_qty;
    end else if (s1_valid && wr_on_s1) begin
      s1_kill  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_slot  <= '0;
      o_key   <= '0;
      o_side  <= 1'b0;
      o_price <= '0;
      o_qty   <= '0;
    end else if (advance) begin
      o_valid <= s1_valid;
      o_slot  <= s1_slot;
      o_key   <= s1_key;
      o_side  <= s1_side;
      o_price <= s1_price;
      o_qty   <= s1_send;
    end
  end

  AST_STALL_BLOCKS_QUOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> !q_ready); // R11

  AST_STALL_HOLDS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_qty) && $stable(o_price) && $stable(o_slot))); // R11

  AST_ORDER_QTY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_qty != '0)); // R5

  AST_STAGE_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && advance) |=> o_valid); // R9

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_any) |=> !s1_valid); // R9

endmodule

// File: tb/order_match_store_bench.sv
module order_match_store_bench;
  localparam int DEPTH = 200;
  localparam int SW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [15:0] wr_key = '0;
  logic wr_side = 1'b0;
  logic [31:0] wr_price = '0;
  logic [23:0] wr_qty = '0;
  logic q_valid = 1'b0;
  logic q_ready;
  logic [15:0] q_key = '0;
  logic [31:0] q_bid = '0, q_ask = '0;
  logic [23:0] q_size = '0;
  logic o_valid;
  logic o_ready = 1'b1;
  logic [SW-1:0] o_slot;
  logic [15:0] o_key;
  logic o_side;
  logic [31:0] o_price;
  logic [23:0] o_qty;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  order_match_store #(.DEPTH(DEPTH)) u_order_match_store (
    .clk, .rst_n, .wr_en, .wr_slot, .wr_key, .wr_side, .wr_price, .wr_qty,
    .q_valid, .q_ready, .q_key, .q_bid, .q_ask, .q_size,
    .o_valid, .o_ready, .o_slot, .o_key, .o_side, .o_price, .o_qty
  );

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic expect_order(string req, logic v, int slot, int price, int qty);
    checks++;
    if (o_valid !== v || (v && (int'(o_slot) != slot || int'(o_price) != price ||
                                int'(o_qty) != qty))) begin
      bad++;
      $display("FAIL %s: got v=%0b slot=%0d price=%0d qty=%0d expected v=%0b slot=%0d price=%0d qty=%0d",
               req, o_valid, o_slot, o_price, o_qty, v, slot, price, qty);
    end
  endtask

  task automatic put(int slot, int key, logic side, int price, int qty);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(slot); wr_key = 16'(key);
    wr_side = side; wr_price = 32'(price); wr_qty = 24'(qty);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic q_drive(int key, int bid, int ask, int size);
    @(negedge clk);
    q_valid = 1'b1; q_key = 16'(key); q_bid = 32'(bid); q_ask = 32'(ask); q_size = 24'(size);
  endtask

  task automatic q_idle();
    @(negedge clk);
    q_valid = 1'b0;
  endtask

  // presents a quote in cycle n, leaves time at cycle n+2
  task automatic quote(int key, int bid, int ask, int size);
    q_drive(key, bid, ask, size);
    q_idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_bit("R1 o_valid after reset", o_valid, 1'b0);
    check_bit("R1 q_ready after reset", q_ready, 1'b1);
    quote(7, 0, 0, 5);
    expect_order("R1 empty table", 1'b0, 0, 0, 0);
  endtask

  task automatic t_buy();
    put(5, 7, 1'b0, 100, 50);
    quote(7, 0, 101, 20);
    expect_order("R2 ask above limit", 1'b0, 0, 0, 0);
    quote(8, 0, 100, 20);
    expect_order("R2 key differs", 1'b0, 0, 0, 0);
    q_drive(7, 0, 100, 20);
    q_idle();
    check_bit("R9 not yet at n+1", o_valid, 1'b0);
    @(negedge clk);
    expect_order("R2 R9 buy at limit", 1'b1, 5, 100, 20);
    checks++;
    if (o_key !== 16'd7 || o_side !== 1'b0) begin
      bad++;
      $display("FAIL R5 fields: got key=%0d side=%0b expected key=7 side=0", o_key, o_side);
    end
    quote(7, 0, 90, 40);
    expect_order("R6 remainder capped", 1'b1, 5, 100, 30);
    quote(7, 0, 90, 40);
    expect_order("R6 buy slot retired", 1'b0, 0, 0, 0);
  endtask

  task automatic t_sell();
    put(9, 3, 1'b1, 200, 10);
    quote(3, 199, 0, 5);
    expect_order("R3 bid below limit", 1'b0, 0, 0, 0);
    quote(3, 200, 0, 0);
    expect_order("R2 zero size", 1'b0, 0, 0, 0);
    quote(3, 200, 0, 30);
    expect_order("R3 R5 sell at limit", 1'b1, 9, 200, 10);
    quote(3, 250, 0, 30);
    expect_order("R6 sell slot retired", 1'b0, 0, 0, 0);
  endtask

  task automatic t_priority();
    put(20, 8, 1'b0, 50, 5);
    put(12, 8, 1'b0, 50, 5);
    quote(8, 0, 40, 3);
    expect_order("R4 lowest slot", 1'b1, 12, 50, 3);
    quote(8, 0, 40, 9);
    expect_order("R4 R6 drain low slot", 1'b1, 12, 50, 2);
    quote(8, 0, 40, 9);
    expect_order("R4 next slot", 1'b1, 20, 50, 5);
  endtask

  task automatic t_back_to_back();
    put(30, 11, 1'b0, 10, 6);
    q_drive(11, 0, 10, 4);
    q_drive(11, 0, 10, 4);
    q_drive(11, 0, 10, 4);
    expect_order("R10 first", 1'b1, 30, 10, 4);
    q_idle();
    expect_order("R10 second sees decrement", 1'b1, 30, 10, 2);
    @(negedge clk);
    expect_order("R10 third finds empty", 1'b0, 0, 0, 0);
  endtask

  task automatic t_writes();
    put(40, 12, 1'b0, 100, 5);
    put(40, 12, 1'b0, 100, 0);
    quote(12, 0, 1, 5);
    expect_order("R7 zero write empties", 1'b0, 0, 0, 0);
    put(250, 13, 1'b0, 100, 5);
    quote(13, 0, 1, 5);
    expect_order("R7 out-of-range write", 1'b0, 0, 0, 0);
    put(41, 12, 1'b1, 70, 4);
    quote(12, 70, 0, 9);
    expect_order("R7 write stores fields", 1'b1, 41, 70, 4);
  endtask

  task automatic t_clash();
    put(50, 14, 1'b0, 10, 8);
    q_drive(14, 0, 5, 3);
    @(negedge clk);
    q_valid = 1'b0;
    wr_en = 1'b1; wr_slot = SW'(50); wr_key = 16'd14; wr_side = 1'b0;
    wr_price = 32'd10; wr_qty = 24'd100;
    @(negedge clk);
    wr_en = 1'b0;
    expect_order("R8 chosen order still sent", 1'b1, 50, 10, 3);
    quote(14, 0, 5, 200);
    expect_order("R8 write beats decrement", 1'b1, 50, 10, 100);
  endtask

  task automatic t_stall();
    put(60, 15, 1'b0, 10, 9);
    o_ready = 1'b0;
    quote(15, 0, 5, 2);
    expect_order("R11 order appears", 1'b1, 60, 10, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_order("R11 order held", 1'b1, 60, 10, 2);
      check_bit("R11 quotes blocked", q_ready, 1'b0);
    end
    o_ready = 1'b1;
    @(negedge clk);
    check_bit("R11 order leaves", o_valid, 1'b0);
    quote(15, 0, 5, 100);
    expect_order("R11 decrement kept", 1'b1, 60, 10, 7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buy();
    t_sell();
    t_priority();
    t_back_to_back();
    t_writes();
    t_clash();
    t_stall();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule